// File: doc/BRIEF.md
# Accumulator Datapath Unit with Flag Register

This unit is the arithmetic and logic stage of a small accumulator-style processor core. It holds the working register (the accumulator) and the three low status flags. Each operation combines the accumulator with a file-register operand supplied by the surrounding core. The unit drives a result byte and steers it either into the accumulator or out to the file-register write port. The rest of the core takes care of fetch, decode, paging and the upper status bits. It presents the file operand, an operation code, a destination bit and a one-cycle valid strobe.

The packed status byte the core sees is assembled from two sources. Its three low bits come from the unit's own flag register: zero at bit 2, digit carry at bit 1 and carry at bit 0. Its five high bits are copied straight from the status byte the core supplies. The rotates always run through the carry held in the unit's flag register.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `w_q` to 0x00 and clears `stat_out[2:0]`.
- R2: Codes 0, 1 and 2 give `w_q & file_in`, `w_q | file_in` and `w_q ^ file_in`. Z (bit 2) is set when the result is zero and cleared otherwise. C (bit 0) and DC (bit 1) are unchanged.
- R3: Code 3 gives `~file_in` and code 4 gives `~w_q`. Z follows the result, and C and DC are unchanged.
- R4: Code 5 rotates left through carry: the result is `{file_in[6:0], C}` and the new C is `file_in[7]`. Code 6 rotates right through carry: the result is `{C, file_in[7:1]}` and the new C is `file_in[0]`. Z and DC are unchanged.
- R5: Code 7 gives `{file_in[3:0], file_in[7:4]}` and always writes it to the accumulator, whatever `dest_sel` holds. All three flags are unchanged.
- R6: Code 8 gives `file_in + 1` and code 9 gives `file_in - 1`, both modulo 256. Z follows the result, and C and DC are unchanged.
- R7: Code 10 gives `w_q + file_in`. C is the carry out of bit 7, DC is the carry out of bit 3, and Z follows the 8-bit result.
- R8: Code 11 gives `file_in - w_q`. C is 1 when no borrow occurs out of bit 7. DC is 1 when no borrow occurs out of bit 3. Z follows the result.
- R9: For a valid operation with `dest_sel`=0, `w_we` is high in that cycle and `w_q` takes the result at the next edge. With `dest_sel`=1, `f_we` is high, `f_wdata` equals the result and `w_q` holds. The code 7 exception in R5 applies.
- R10: `stat_out[7:3]` always equals `stat_in[7:3]`. `stat_in[2:0]` has no effect on any output.
- R11: When `op_valid` is low, or the code is 12 to 15, both write enables stay low and `w_q` and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code (0 to 11 defined) |
| dest_sel | input | 1 | 0 = accumulator, 1 = file register |
| file_in | input | 8 | File-register operand |
| stat_in | input | 8 | Current status byte; bits 7:3 pass through |
| result | output | 8 | Combinational operation result |
| w_we | output | 1 | Accumulator load this cycle |
| f_we | output | 1 | File-register write this cycle |
| f_wdata | output | 8 | File-register write data |
| w_q | output | 8 | Accumulator contents |
| stat_out | output | 8 | Status byte: flags in 2:0, `stat_in[7:3]` above |

## Verification
The embedded properties run on every cycle. They check that the two write enables are never high together, that the accumulator and flags hold for strobes that are invalid or carry an undefined code, and that rotates and swaps leave the flags they must not touch. They also check the add carry against an independent 9-bit sum, the swap's forced accumulator destination, and the reset values. The exact result values for every code, the digit-carry and borrow edges (0x0F+0x01, 0xFF+0x01, x-x, 0-1), and carry chaining through successive rotates can only be shown by the bench's reference model. The same holds for the unaffected upper status bits under random `stat_in`.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int unsigned DW    = 8;
    localparam int unsigned NIB   = DW / 2;
    localparam int unsigned FLAGW = 3;
    localparam int unsigned OPW   = 4;

    typedef enum logic [OPW-1:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_NOTF = 4'd3,
        OP_NOTW = 4'd4,
        OP_ROL  = 4'd5,
        OP_ROR  = 4'd6,
        OP_SWAP = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_ADD  = 4'd10,
        OP_SUB  = 4'd11
    } op_e;

    // Packed so that z lands at bit 2, dc at bit 1 and c at bit 0
    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] w;
        flags_t        fl;
    } core_state_t;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import acc_alu_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a_w,
    input  logic [DW-1:0]  a_f,
    input  logic           c_in,
    output logic [DW-1:0]  res,
    output logic           c_out,
    output logic           hit,
    output logic           upd_z,
    output logic           upd_c
);
    always_comb begin
        res   = '0;
        c_out = c_in;
        hit   = 1'b1;
        upd_z = 1'b0;
        upd_c = 1'b0;
        unique case (op)
            OP_AND:  begin res = a_w & a_f; upd_z = 1'b1; end
            OP_OR:   begin res = a_w | a_f; upd_z = 1'b1; end
            OP_XOR:  begin res = a_w ^ a_f; upd_z = 1'b1; end
            OP_NOTF: begin res = ~a_f;      upd_z = 1'b1; end
            OP_NOTW: begin res = ~a_w;      upd_z = 1'b1; end
            OP_ROL: begin
                res   = {a_f[DW-2:0], c_in};
                c_out = a_f[DW-1];
                upd_c = 1'b1;
            end
            OP_ROR: begin
                res   = {c_in, a_f[DW-1:1]};
                c_out = a_f[0];
                upd_c = 1'b1;
            end
            OP_SWAP: res = {a_f[NIB-1:0], a_f[DW-1:NIB]};
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import acc_alu_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a_w,
    input  logic [DW-1:0]  a_f,
    output logic [DW-1:0]  res,
    output logic           c_out,
    output logic           dc_out,
    output logic           hit,
    output logic           upd_cdc
);
    logic [DW:0]  wide;
    logic [NIB:0] low;

    always_comb begin
        wide    = '0;
        low     = '0;
        hit     = 1'b1;
        upd_cdc = 1'b0;
        unique case (op)
            OP_INC: wide = {1'b0, a_f} + {{DW{1'b0}}, 1'b1};
            OP_DEC: wide = {1'b0, a_f} - {{DW{1'b0}}, 1'b1};
            OP_ADD: begin
                wide    = {1'b0, a_w} + {1'b0, a_f};
                low     = {1'b0, a_w[NIB-1:0]} + {1'b0, a_f[NIB-1:0]};
                upd_cdc = 1'b1;
            end
            OP_SUB: begin
                wide    = {1'b0, a_f} - {1'b0, a_w};
                low     = {1'b0, a_f[NIB-1:0]} - {1'b0, a_w[NIB-1:0]};
                upd_cdc = 1'b1;
            end
            default: hit = 1'b0;
        endcase
        res = wide[DW-1:0];
        // Subtract reports the inverted borrow in both carry flags
        if (op == OP_SUB) begin
            c_out  = ~wide[DW];
            dc_out = ~low[NIB];
        end else begin
            c_out  = wide[DW];
            dc_out = low[NIB];
        end
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_sel,
    input  logic           dest_sel,
    input  logic [DW-1:0]  file_in,
    input  logic [DW-1:0]  stat_in,
    output logic [DW-1:0]  result,
    output logic           w_we,
    output logic           f_we,
    output logic [DW-1:0]  f_wdata,
    output logic [DW-1:0]  w_q,
    output logic [DW-1:0]  stat_out
);
    core_state_t st_q, st_d;

    logic [DW-1:0] lg_res, ar_res;
    logic          lg_c, lg_hit, lg_upd_z, lg_upd_c;
    logic          ar_c, ar_dc, ar_hit, ar_upd_cdc;
    logic          legal, fire, to_w;

    alu_logic_unit u_logic (
        .op    (op_sel),
        .a_w   (st_q.w),
        .a_f   (file_in),
        .c_in  (st_q.fl.c),
        .res   (lg_res),
        .c_out (lg_c),
        .hit   (lg_hit),
        .upd_z (lg_upd_z),
        .upd_c (lg_upd_c)
    );

    alu_arith_unit u_arith (
        .op      (op_sel),
        .a_w     (st_q.w),
        .a_f     (file_in),
        .res     (ar_res),
        .c_out   (ar_c),
        .dc_out  (ar_dc),
        .hit     (ar_hit),
        .upd_cdc (ar_upd_cdc)
    );

    always_comb begin
        legal  = lg_hit | ar_hit;
        fire   = op_valid & legal;
        result = ar_hit ? ar_res : lg_res;
        to_w   = (dest_sel == 1'b0) || (op_sel == OP_SWAP);
        w_we   = fire & to_w;
        f_we   = fire & ~to_w;
        st_d   = st_q;
        if (w_we) st_d.w = result;
        if (fire) begin
            if (lg_upd_z || ar_hit) st_d.fl.z  = (result == '0);
            if (lg_upd_c)           st_d.fl.c  = lg_c;
            if (ar_upd_cdc) begin
                st_d.fl.c  = ar_c;
                st_d.fl.dc = ar_dc;
            end
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign f_wdata  = result;
    assign w_q      = st_q.w;
    assign stat_out = {stat_in[DW-1:FLAGW], st_q.fl};

    // R9: only one destination is written per operation
    a_r9_one_dest: assert property (@(posedge clk) disable iff (rst)
        $onehot0({w_we, f_we}));

    // R5: the swap code is forced to the accumulator
    a_r5_swap_to_w: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_SWAP) |-> (w_we && !f_we));

    // R5: the swap leaves every flag alone
    a_r5_swap_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_SWAP) |=> (stat_out[2:0] == $past(stat_out[2:0])));

    // R4: rotates keep Z and DC
    a_r4_rot_keep: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_ROL || op_sel == OP_ROR))
        |=> (stat_out[2:1] == $past(stat_out[2:1])));

    // R11: idle or undefined strobes change nothing
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_sel > OP_SUB)
        |=> (w_q == $past(w_q) && stat_out[2:0] == $past(stat_out[2:0])));

    // R7: add carry agrees with a 9-bit sum
    a_r7_add_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_ADD)
        |=> (stat_out[0] == (({1'b0, $past(w_q)} + {1'b0, $past(file_in)}) > 9'd255)));

    // R1: reset clears the accumulator and the flags
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (w_q == '0 && stat_out[2:0] == '0));
endmodule

// File: tb/acc_alu_core_bench.sv
`timescale 1ns/1ps
module acc_alu_core_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [3:0] op_sel;
    logic       dest_sel;
    logic [7:0] file_in;
    logic [7:0] stat_in;
    logic [7:0] result, f_wdata, w_q, stat_out;
    logic       w_we, f_we;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_w;
    logic [2:0] m_fl;

    always #4 clk = ~clk;

    acc_alu_core u_acc_alu_core (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .dest_sel(dest_sel), .file_in(file_in), .stat_in(stat_in),
        .result(result), .w_we(w_we), .f_we(f_we), .f_wdata(f_wdata),
        .w_q(w_q), .stat_out(stat_out)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            0, 1, 2: return "R2";
            3, 4:    return "R3";
            5, 6:    return "R4";
            7:       return "R5";
            8, 9:    return "R6";
            10:      return "R7";
            11:      return "R8";
            default: return "R11";
        endcase
    endfunction

    // Returns {legal, flags[2:0], result[7:0]}; flags ordered z,dc,c
    function automatic logic [11:0] model(input logic [3:0] op, input logic [7:0] w,
                                          input logic [7:0] f, input logic [2:0] fl);
        logic [7:0] r;
        logic z, dc, c;
        logic [8:0] s;
        logic [4:0] n;
        z = fl[2]; dc = fl[1]; c = fl[0];
        r = 8'h00;
        case (op)
            0: r = w & f;
            1: r = w | f;
            2: r = w ^ f;
            3: r = ~f;
            4: r = ~w;
            5: begin r = {f[6:0], fl[0]}; c = f[7]; end
            6: begin r = {fl[0], f[7:1]}; c = f[0]; end
            7: r = {f[3:0], f[7:4]};
            8: r = f + 8'd1;
            9: r = f - 8'd1;
            10: begin
                s = w + f; n = w[3:0] + f[3:0];
                r = s[7:0]; c = s[8]; dc = n[4];
            end
            11: begin
                r = f - w; c = (f >= w); dc = (f[3:0] >= w[3:0]);
            end
            default: return {1'b0, fl, 8'h00};
        endcase
        if (op != 5 && op != 6 && op != 7) z = (r == 8'h00);
        return {1'b1, z, dc, c, r};
    endfunction

    task automatic do_op(input logic [3:0] op, input logic dst, input logic [7:0] f,
                         input logic vld, input logic [7:0] st);
        logic [11:0] e;
        logic ew, ef;
        string t;
        @(negedge clk);
        op_sel = op; dest_sel = dst; file_in = f; op_valid = vld; stat_in = st;
        #1;
        e  = model(op, m_w, f, m_fl);
        t  = tag_of(op);
        ew = vld && e[11] && (dst == 1'b0 || op == 4'd7);
        ef = vld && e[11] && dst == 1'b1 && op != 4'd7;
        chk({7'd0, w_we}, {7'd0, ew}, (op == 7) ? "R5" : (vld && e[11]) ? "R9" : "R11");
        chk({7'd0, f_we}, {7'd0, ef}, (vld && e[11]) ? "R9" : "R11");
        if (vld && e[11]) chk(result, e[7:0], t);
        if (ef) chk(f_wdata, e[7:0], "R9");
        chk({3'd0, stat_out[7:3]}, {3'd0, st[7:3]}, "R10");
        @(posedge clk);
        #1;
        if (vld && e[11]) m_fl = e[10:8];
        if (ew) m_w = e[7:0];
        chk(w_q, m_w, (vld && e[11]) ? t : "R11");
        chk({5'd0, stat_out[2:0]}, {5'd0, m_fl}, (vld && e[11]) ? t : "R11");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        rst = 1'b1; op_valid = 1'b1; op_sel = 4'd4; dest_sel = 1'b0;
        file_in = 8'hA5; stat_in = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state despite a valid strobe
        chk(w_q, 8'h00, "R1");
        chk({5'd0, stat_out[2:0]}, 8'h00, "R1");
        chk({3'd0, stat_out[7:3]}, 8'h1F, "R10");
        @(negedge clk);
        rst = 1'b0; op_valid = 1'b0;
        m_w = 8'h00; m_fl = 3'b000;

        // Directed corners
        do_op(4'd3, 1'b0, 8'hF0, 1'b1, 8'h00);  // W = 0F (R3)
        do_op(4'd10, 1'b0, 8'h01, 1'b1, 8'h07); // 0F+01: DC only (R7), stat_in[2:0] ignored (R10)
        do_op(4'd3, 1'b0, 8'h00, 1'b1, 8'hA8);  // W = FF
        do_op(4'd10, 1'b1, 8'h01, 1'b1, 8'h00); // FF+01 = 00: C,DC,Z, to file (R7, R9)
        do_op(4'd11, 1'b0, 8'hFF, 1'b1, 8'h00); // FF-FF = 00, no borrow (R8)
        do_op(4'd11, 1'b1, 8'h00, 1'b1, 8'h00); // 00-00 with W=0
        do_op(4'd8, 1'b0, 8'h00, 1'b1, 8'h00);  // W = 01 (R6)
        do_op(4'd11, 1'b0, 8'h00, 1'b1, 8'h00); // 00-01 = FF, borrows (R8)
        do_op(4'd9, 1'b1, 8'h01, 1'b1, 8'h00);  // dec to zero (R6)
        do_op(4'd8, 1'b1, 8'hFF, 1'b1, 8'h00);  // inc wraps (R6)
        do_op(4'd5, 1'b1, 8'h80, 1'b1, 8'h00);  // rotate left, C chains (R4)
        do_op(4'd5, 1'b1, 8'h00, 1'b1, 8'h00);
        do_op(4'd6, 1'b0, 8'h01, 1'b1, 8'h00);  // rotate right (R4)
        do_op(4'd7, 1'b1, 8'h3C, 1'b1, 8'h00);  // swap forced to W (R5)
        do_op(4'd4, 1'b0, 8'h00, 1'b1, 8'h00);  // complement W (R3)
        do_op(4'd0, 1'b0, 8'h00, 1'b1, 8'h00);  // AND to zero (R2)
        do_op(4'd13, 1'b0, 8'h55, 1'b1, 8'h00); // undefined code (R11)
        do_op(4'd10, 1'b0, 8'h55, 1'b0, 8'h00); // idle strobe (R11)

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            op = (($urandom % 8) == 0) ? 4'($urandom % 16) : 4'($urandom % 12);
            do_op(op, 1'($urandom), 8'($urandom), (($urandom % 10) != 0), 8'($urandom));
        end
        finish_run();
    end
endmodule